// File: doc/BRIEF.md
# Steerable Timekeeper Watchdog

This block is the watchdog portion of a timekeeping device. Software programs it by writing one byte. The low two bits choose a resolution, bits 6:2 give a multiplier, and bit 7 steers what happens when the timer expires. The block counts down on a 16 Hz tick input that comes from elsewhere. When the count runs out, the block sets a flag that software can see in a read-only flags byte. Depending on the steering bit, it then either pulses an interrupt line or raises a one-cycle request for a system reset.

Software keeps the watchdog alive in one of two ways: by rewriting the watchdog byte, or by reading the flags byte. A flags read reloads the countdown from the byte already stored. The block also holds a control byte that belongs to a neighbouring register. When an expiry takes the reset path, the block clears bit 6 of that control byte and wipes the stored watchdog byte to zero.

Top module: `tk_watchdog`

## Requirements
- R1: After reset the watchdog byte, the control byte, the flags byte, `irq` and `rst_req` are all zero.
- R2: A write of the watchdog byte stores it, clears the expiry flag (bit 7 of the flags byte) and restarts the countdown from the new value.
- R3: The countdown length in ticks is the multiplier (bits 6:2) times 4 raised to the resolution (bits 1:0). Expiry happens on exactly that tick and not one tick sooner. Without a tick the count holds.
- R4: A multiplier of zero disables the countdown, so no number of ticks causes an expiry.
- R5: On expiry with bit 7 of the watchdog byte set, the flag is set, the watchdog byte becomes 0x00, bit 6 of the control byte is cleared (its other bits are kept), and `rst_req` pulses high for exactly one cycle with no `irq`.
- R6: On expiry with bit 7 clear, the flag is set, `irq` pulses high for exactly one cycle, `rst_req` stays low, and the watchdog byte and control byte are unchanged.
- R7: A read strobe of the flags byte clears the flag and restarts the countdown from the stored watchdog byte.
- R8: A write strobe to the flags byte has no effect. Bits 6:0 of the flags byte always read zero.
- R9: After an expiry the countdown is stopped. Further ticks produce no further pulses until a reload.
- R10: A reload in the same cycle as the final tick wins. No expiry occurs, and the full interval restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe at 16 Hz |
| wd_wr_en | input | 1 | Write strobe for the watchdog byte |
| wd_wr_data | input | 8 | Watchdog byte: [7] steer, [6:2] multiplier, [1:0] resolution |
| flg_rd_en | input | 1 | Read strobe of the flags byte (reload) |
| flg_wr_en | input | 1 | Write strobe to the flags byte (ignored) |
| ctl_wr_en | input | 1 | Write strobe for the control byte |
| ctl_wr_data | input | 8 | Control byte write data |
| wd_q | output | 8 | Stored watchdog byte |
| ctl_q | output | 8 | Stored control byte |
| flags_q | output | 8 | Flags byte, expiry flag in bit 7 |
| irq | output | 1 | One-cycle interrupt pulse on expiry |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
A countdown that is off by one, or that ignores the resolution, shows up as a flag and a pulse one tick early or late. The bench therefore samples after every tick near the end of each interval. A lost reload, or a counter that keeps running after expiry, produces a missing or repeated pulse within a few ticks. A steering decode error is visible in the same cycle as the expiry, on the wrong pulse pin and on the watchdog and control bytes. Each case is checked in the cycle that follows the tick edge.

// File: rtl/tkwd_pkg.sv
package tkwd_pkg;
  localparam int BYTE_W      = 8;
  localparam int RES_W       = 2;
  localparam int MULT_W      = 5;
  localparam int RES_N       = 1 << RES_W;
  localparam int SHIFT_MAX   = 2 * (RES_N - 1);
  localparam int CNT_W       = MULT_W + SHIFT_MAX;
  localparam int STEER_BIT   = 7;
  localparam int FLAG_BIT    = 7;
  localparam int CTL_CLR_BIT = 6;
  typedef logic [CNT_W-1:0] ticks_t;
endpackage

// File: rtl/tk_wd_decode.sv
module tk_wd_decode
  import tkwd_pkg::*;
(
  input  logic [MULT_W+RES_W-1:0] cfg,
  output ticks_t                  interval
);
  logic [MULT_W-1:0] mult;
  logic [RES_W-1:0]  res;
  ticks_t            opt [RES_N];

  assign mult = cfg[MULT_W+RES_W-1:RES_W];
  assign res  = cfg[RES_W-1:0];

  for (genvar r = 0; r < RES_N; r++) begin : g_res
    assign opt[r] = ticks_t'(mult) << (2 * r);
  end

  assign interval = opt[res];

  always_comb begin
    if (mult == '0) begin
      a_zero_mult_r4 : assert (interval == '0);
    end
  end
endmodule

// File: rtl/tk_wd_counter.sv
module tk_wd_counter
  import tkwd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  ticks_t load_val,
  input  logic   tick,
  output logic   expire
);
  localparam ticks_t MAX_CNT = ticks_t'(((1 << MULT_W) - 1) << SHIFT_MAX);

  ticks_t count_q, count_d;
  logic   cnt_en;

  assign cnt_en = load || (tick && (count_q != '0));
  assign expire = tick && !load && (count_q == ticks_t'(1));

  always_comb begin
    count_d = count_q;
    if (load) begin
      count_d = load_val;
    end else if (tick && (count_q != '0)) begin
      count_d = count_q - ticks_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (cnt_en) begin
      count_q <= count_d;
    end
  end

  p_hold_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(count_q));
  p_range_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= MAX_CNT);
  p_stop_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (count_q == '0));
endmodule

// File: rtl/tk_wd_action.sv
module tk_wd_action
  import tkwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wd_wr_en,
  input  logic [BYTE_W-1:0] wd_wr_data,
  input  logic              flg_rd_en,
  input  logic              flg_wr_en,
  input  logic              ctl_wr_en,
  input  logic [BYTE_W-1:0] ctl_wr_data,
  input  logic              expire,
  output logic [BYTE_W-1:0] wd_q,
  output logic [BYTE_W-1:0] ctl_q,
  output logic              flag_q,
  output logic              irq_q,
  output logic              rst_req_q
);
  logic [BYTE_W-1:0] wd_d, ctl_d;
  logic              flag_d, irq_d, rst_req_d;

  always_comb begin
    wd_d      = wd_q;
    ctl_d     = ctl_q;
    flag_d    = flag_q;
    irq_d     = 1'b0;
    rst_req_d = 1'b0;
    if (ctl_wr_en) begin
      ctl_d = ctl_wr_data;
    end
    if (wd_wr_en) begin
      wd_d   = wd_wr_data;
      flag_d = 1'b0;
    end else if (flg_rd_en) begin
      flag_d = 1'b0;
    end
    if (expire) begin
      flag_d = 1'b1;
      if (wd_q[STEER_BIT]) begin
        wd_d               = '0;
        ctl_d[CTL_CLR_BIT] = 1'b0;
        rst_req_d          = 1'b1;
      end else begin
        irq_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q      <= '0;
      ctl_q     <= '0;
      flag_q    <= 1'b0;
      irq_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      wd_q      <= wd_d;
      ctl_q     <= ctl_d;
      flag_q    <= flag_d;
      irq_q     <= irq_d;
      rst_req_q <= rst_req_d;
    end
  end

  p_rst_pulse_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |=> !rst_req_q);
  p_rst_clears_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |-> (flag_q && (wd_q == '0) && !ctl_q[CTL_CLR_BIT]));
  p_irq_pulse_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  p_excl_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_q && rst_req_q));
  p_irq_flag_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> flag_q);
  p_read_clears_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (flg_rd_en && !expire) |=> !flag_q);
  p_flag_wr_ignored_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (flg_wr_en && !wd_wr_en && !flg_rd_en && !expire) |=> $stable(flag_q));
endmodule

// File: rtl/tk_watchdog.sv
module tk_watchdog
  import tkwd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wd_wr_en,
  input  logic [7:0]  wd_wr_data,
  input  logic        flg_rd_en,
  input  logic        flg_wr_en,
  input  logic        ctl_wr_en,
  input  logic [7:0]  ctl_wr_data,
  output logic [7:0]  wd_q,
  output logic [7:0]  ctl_q,
  output logic [7:0]  flags_q,
  output logic        irq,
  output logic        rst_req
);
  logic                     reload;
  logic [MULT_W+RES_W-1:0]  cfg_sel;
  ticks_t                   interval;
  logic                     expire;
  logic                     flag;

  assign reload  = wd_wr_en || flg_rd_en;
  assign cfg_sel = wd_wr_en ? wd_wr_data[MULT_W+RES_W-1:0] : wd_q[MULT_W+RES_W-1:0];

  tk_wd_decode u_decode (
    .cfg      (cfg_sel),
    .interval (interval)
  );

  tk_wd_counter u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (reload),
    .load_val (interval),
    .tick     (tick),
    .expire   (expire)
  );

  tk_wd_action u_action (
    .clk         (clk),
    .rst_n       (rst_n),
    .wd_wr_en    (wd_wr_en),
    .wd_wr_data  (wd_wr_data),
    .flg_rd_en   (flg_rd_en),
    .flg_wr_en   (flg_wr_en),
    .ctl_wr_en   (ctl_wr_en),
    .ctl_wr_data (ctl_wr_data),
    .expire      (expire),
    .wd_q        (wd_q),
    .ctl_q       (ctl_q),
    .flag_q      (flag),
    .irq_q       (irq),
    .rst_req_q   (rst_req)
  );

  always_comb begin
    flags_q           = '0;
    flags_q[FLAG_BIT] = flag;
  end
endmodule

// File: tb/tk_watchdog_bench.sv
module tk_watchdog_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wd_wr_en = 1'b0;
  logic [7:0] wd_wr_data = '0;
  logic       flg_rd_en = 1'b0;
  logic       flg_wr_en = 1'b0;
  logic       ctl_wr_en = 1'b0;
  logic [7:0] ctl_wr_data = '0;
  logic [7:0] wd_q, ctl_q, flags_q;
  logic       irq, rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tk_watchdog u_tk_watchdog (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wd_wr_en(wd_wr_en), .wd_wr_data(wd_wr_data),
    .flg_rd_en(flg_rd_en), .flg_wr_en(flg_wr_en),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .wd_q(wd_q), .ctl_q(ctl_q), .flags_q(flags_q),
    .irq(irq), .rst_req(rst_req)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      step();
      tick = 1'b0;
    end
  endtask

  task automatic wd_write(input logic [7:0] v);
    wd_wr_en = 1'b1; wd_wr_data = v;
    step();
    wd_wr_en = 1'b0;
  endtask

  task automatic flag_read();
    flg_rd_en = 1'b1;
    step();
    flg_rd_en = 1'b0;
  endtask

  task automatic ctl_write(input logic [7:0] v);
    ctl_wr_en = 1'b1; ctl_wr_data = v;
    step();
    ctl_wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "wd byte", wd_q, 8'h00);
    chk("R1", "ctl byte", ctl_q, 8'h00);
    chk("R1", "flags", flags_q, 8'h00);
    chk("R1", "irq", irq, 0);
    chk("R1", "rst_req", rst_req, 0);
  endtask

  task automatic t_interval(input logic [7:0] v, input int n);
    wd_write(v);
    chk("R2", "stored byte", wd_q, v);
    chk("R2", "flag cleared", flags_q, 8'h00);
    ticks(n - 1);
    chk("R3", "no expiry one tick early", flags_q, 8'h00);
    chk("R3", "no irq early", irq, 0);
    step();
    chk("R3", "count holds without tick", flags_q, 8'h00);
    ticks(1);
    chk("R3", "flag on final tick", flags_q, 8'h80);
    chk("R6", "irq pulse", irq, 1);
    chk("R6", "no rst_req", rst_req, 0);
    chk("R6", "wd byte kept", wd_q, v);
    step();
    chk("R6", "irq one cycle", irq, 0);
  endtask

  task automatic t_zero_mult();
    wd_write(8'h03);
    ticks(200);
    chk("R4", "no flag with zero multiplier", flags_q, 8'h00);
    chk("R4", "no irq with zero multiplier", irq, 0);
  endtask

  task automatic t_steer();
    ctl_write(8'hFF);
    wd_write(8'h8D);
    ticks(11);
    chk("R5", "no expiry at 11", flags_q, 8'h00);
    ticks(1);
    chk("R5", "flag set", flags_q, 8'h80);
    chk("R5", "rst_req pulse", rst_req, 1);
    chk("R5", "no irq", irq, 0);
    chk("R5", "wd byte wiped", wd_q, 8'h00);
    chk("R5", "ctl bit 6 cleared", ctl_q, 8'hBF);
    step();
    chk("R5", "rst_req one cycle", rst_req, 0);
  endtask

  task automatic t_ctl_kept();
    ctl_write(8'h5A);
    wd_write(8'h04);
    ticks(1);
    chk("R6", "ctl unchanged on irq path", ctl_q, 8'h5A);
    chk("R6", "irq", irq, 1);
  endtask

  task automatic t_one_shot();
    wd_write(8'h08);
    ticks(2);
    chk("R9", "expired", flags_q, 8'h80);
    step();
    for (int i = 0; i < 10; i++) begin
      ticks(1);
      if (irq !== 1'b0 || rst_req !== 1'b0) chk("R9", "no repeat pulse", 1, 0);
    end
    chk("R9", "no pulse after expiry", irq, 0);
    chk("R9", "flag stays", flags_q, 8'h80);
  endtask

  task automatic t_read_reload();
    wd_write(8'h0C);
    ticks(2);
    flag_read();
    ticks(2);
    chk("R7", "read restarted count", flags_q, 8'h00);
    ticks(1);
    chk("R7", "expiry 3 ticks after read", flags_q, 8'h80);
    chk("R7", "irq after read reload", irq, 1);
    flag_read();
    chk("R7", "read clears flag", flags_q, 8'h00);
    ticks(2);
    chk("R7", "reload from stored byte", flags_q, 8'h00);
    ticks(1);
    chk("R7", "expires again from stored byte", flags_q, 8'h80);
  endtask

  task automatic t_flag_write();
    flg_wr_en = 1'b1;
    step();
    flg_wr_en = 1'b0;
    chk("R8", "set flag survives write", flags_q, 8'h80);
    wd_write(8'h0C);
    flg_wr_en = 1'b1;
    step();
    flg_wr_en = 1'b0;
    chk("R8", "clear flag survives write", flags_q, 8'h00);
    ticks(3);
    chk("R8", "write did not reload", flags_q, 8'h80);
  endtask

  task automatic t_reload_wins();
    wd_write(8'h0C);
    ticks(2);
    tick = 1'b1; wd_wr_en = 1'b1; wd_wr_data = 8'h0C;
    step();
    tick = 1'b0; wd_wr_en = 1'b0;
    chk("R10", "no expiry on reload tick", flags_q, 8'h00);
    chk("R10", "no irq on reload tick", irq, 0);
    ticks(2);
    chk("R10", "full interval restarted", flags_q, 8'h00);
    ticks(1);
    chk("R10", "expires after full interval", flags_q, 8'h80);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_interval(8'h0C, 3);
    t_interval(8'h05, 4);
    t_interval(8'h0A, 32);
    t_interval(8'h07, 64);
    t_interval(8'h7F, 1984);
    t_zero_mult();
    t_steer();
    t_ctl_kept();
    t_one_shot();
    t_read_reload();
    t_flag_write();
    t_reload_wins();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule